// File: doc/BRIEF.md
# Eight-Operation Combinational ALU

This block is a combinational arithmetic logic unit. Two operands of WIDTH bits (four by default) and a three-bit operation code produce a WIDTH-bit result, a carry flag and a signed-overflow flag. There is no clock and no reset, and every output follows its inputs within the same evaluation.

The operation code is split into fields. The top bit chooses between a logic section and an arithmetic section. In the logic section the two low bits pick one of four bitwise results. In the arithmetic section a single adder/subtractor is shared by all four operations. The middle bit replaces the second operand with the constant one. The low bit turns the adder into a subtractor by inverting that operand and forcing the carry into the least significant stage. Results wrap modulo 2^WIDTH.

The block suits a datapath that needs a small set of operations without the cost of separate adders for increment and decrement.

Top module: `op8_alu`

## Requirements
- R1: With op_i = 3'b000, f_o equals a_i AND b_i, bit by bit.
- R2: With op_i = 3'b001, f_o equals a_i OR b_i, bit by bit.
- R3: With op_i = 3'b010, f_o equals the bitwise inverse of a_i, and b_i has no effect on f_o.
- R4: With op_i = 3'b011, f_o equals a_i XOR b_i, bit by bit.
- R5: With op_i = 3'b100, f_o equals (a_i + b_i) mod 2^WIDTH. carry_o is the carry out of bit WIDTH-1, so it is 1 exactly when the unsigned sum reaches 2^WIDTH.
- R6: With op_i = 3'b101, f_o equals (a_i - b_i) mod 2^WIDTH. carry_o is 1 exactly when a_i >= b_i as unsigned values, which means no borrow occurred.
- R7: With op_i = 3'b110, f_o equals (a_i + 1) mod 2^WIDTH. b_i has no effect, and carry_o is 1 only when a_i is all ones.
- R8: With op_i = 3'b111, f_o equals (a_i - 1) mod 2^WIDTH. b_i has no effect, and carry_o is 1 exactly when a_i is nonzero.
- R9: For each of the four arithmetic codes (op_i[2] = 1), ovf_o is 1 exactly when the two's-complement result of the operation falls outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. For example, at WIDTH = 4, 0111 + 0111 gives 1110 with ovf_o = 1, and 1001 + 1001 gives 0010 with ovf_o = 1.
- R10: Whenever op_i[2] = 0, carry_o and ovf_o are both 0.
- R11: All outputs are a combinational function of the current inputs. A change on the inputs at any time, with no clock edge, shows at the outputs after settling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, used by AND, OR, XOR, add and subtract |
| op_i | input | 3 | Operation code: bit 2 selects arithmetic, bit 1 selects the constant one, bit 0 selects subtract |
| f_o | output | WIDTH | Result, modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top adder stage; 0 for logic codes |
| ovf_o | output | 1 | Two's-complement overflow; 0 for logic codes |

## Verification
The block holds no state, so a wrong internal value appears at the ports at once, in the same evaluation as the input that exposes it. A fault in a single ripple stage or in the carry into the top stage corrupts f_o, carry_o or ovf_o only for the operand pairs whose carry reaches that stage. A decode fault in the operand-replacement or inversion path changes whole operation codes. Sweeping every operand pair under every code therefore exposes each such fault on at least one vector. Directed corner pairs confirm the wrap and overflow edges.

// File: rtl/op8_alu_pkg.sv
package op8_alu_pkg;
   typedef enum logic [2:0] {
      OP_AND  = 3'b000,
      OP_OR   = 3'b001,
      OP_NOTA = 3'b010,
      OP_XOR  = 3'b011,
      OP_ADD  = 3'b100,
      OP_SUB  = 3'b101,
      OP_INC  = 3'b110,
      OP_DEC  = 3'b111
   } alu_op_e;

   localparam int unsigned OP_BITS       = 3;
   localparam int unsigned SEL_ARITH_BIT = 2;
   localparam int unsigned SEL_CONST_BIT = 1;
   localparam int unsigned SEL_SUB_BIT   = 0;
   localparam int unsigned LOGIC_SEL_W   = 2;
endpackage

// File: rtl/op8_full_adder.sv
module op8_full_adder (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half;

   always_comb begin
      half = x_i ^ y_i;
      s_o  = half ^ c_i;
      c_o  = (x_i & y_i) | (c_i & half);
   end
endmodule

// File: rtl/op8_ripple_adder.sv
module op8_ripple_adder #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ctop_o
);
   localparam int unsigned TOP = WIDTH - 1;

   logic [WIDTH:0] chain;

   assign chain[0] = cin_i;

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      op8_full_adder u_fa (
         .x_i (x_i[k]),
         .y_i (y_i[k]),
         .c_i (chain[k]),
         .s_o (sum_o[k]),
         .c_o (chain[k+1])
      );
   end

   assign cout_o = chain[WIDTH];
   assign ctop_o = chain[TOP];
endmodule

// File: rtl/op8_arith_unit.sv
module op8_arith_unit #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             use_one_i,
   input  logic             subtract_i,
   output logic [WIDTH-1:0] f_o,
   output logic             carry_o,
   output logic             ovf_o
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] operand;
   logic [WIDTH-1:0] addend;
   logic             ctop;
   logic             cout;

   always_comb begin
      operand = use_one_i ? ONE : b_i;
      addend  = operand ^ {WIDTH{subtract_i}};
   end

   op8_ripple_adder #(.WIDTH(WIDTH)) u_adder (
      .x_i    (a_i),
      .y_i    (addend),
      .cin_i  (subtract_i),
      .sum_o  (f_o),
      .cout_o (cout),
      .ctop_o (ctop)
   );

   assign carry_o = cout;
   assign ovf_o   = cout ^ ctop;
endmodule

// File: rtl/op8_logic_unit.sv
module op8_logic_unit
   import op8_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0]       a_i,
   input  logic [WIDTH-1:0]       b_i,
   input  logic [LOGIC_SEL_W-1:0] sel_i,
   output logic [WIDTH-1:0]       f_o
);
   localparam int unsigned NUM_FN = 1 << LOGIC_SEL_W;

   for (genvar k = 0; k < WIDTH; k++) begin : g_slice
      logic [NUM_FN-1:0] cand;
      always_comb begin
         cand[0] = a_i[k] & b_i[k];
         cand[1] = a_i[k] | b_i[k];
         cand[2] = ~a_i[k];
         cand[3] = a_i[k] ^ b_i[k];
      end
      assign f_o[k] = cand[sel_i];
   end
endmodule

// File: rtl/op8_alu.sv
module op8_alu
   import op8_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0]   a_i,
   input  logic [WIDTH-1:0]   b_i,
   input  logic [OP_BITS-1:0] op_i,
   output logic [WIDTH-1:0]   f_o,
   output logic               carry_o,
   output logic               ovf_o
);
   if (WIDTH < 2) begin : g_width_check
      $error("op8_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] logic_f;
   logic [WIDTH-1:0] arith_f;
   logic             arith_c;
   logic             arith_v;
   logic             is_arith;

   assign is_arith = op_i[SEL_ARITH_BIT];

   op8_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a_i   (a_i),
      .b_i   (b_i),
      .sel_i (op_i[LOGIC_SEL_W-1:0]),
      .f_o   (logic_f)
   );

   op8_arith_unit #(.WIDTH(WIDTH)) u_arith (
      .a_i        (a_i),
      .b_i        (b_i),
      .use_one_i  (op_i[SEL_CONST_BIT]),
      .subtract_i (op_i[SEL_SUB_BIT]),
      .f_o        (arith_f),
      .carry_o    (arith_c),
      .ovf_o      (arith_v)
   );

   always_comb begin
      f_o     = is_arith ? arith_f : logic_f;
      carry_o = is_arith & arith_c;
      ovf_o   = is_arith & arith_v;
   end
endmodule

// File: rtl/op8_alu_checker.sv
module op8_alu_checker
   import op8_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input logic [WIDTH-1:0]   a_i,
   input logic [WIDTH-1:0]   b_i,
   input logic [OP_BITS-1:0] op_i,
   input logic [WIDTH-1:0]   f_o,
   input logic               carry_o,
   input logic               ovf_o
);
   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      // R10: logic codes never raise arithmetic flags
      assert_logic_quiet_R10: assert (op_i[SEL_ARITH_BIT] || (!carry_o && !ovf_o))
         else $error("R10: flags set on a logic code");
      // R3: inverse of A regardless of B
      assert_not_a_R3: assert (op_i != OP_NOTA || (f_o ^ a_i) == '1)
         else $error("R3: result is not the inverse of A");
      // R9: add overflow only with equal operand signs and a flipped result sign
      assert_add_ovf_R9: assert (op_i != OP_ADD ||
                                 ovf_o == ((a_i[MSB] == b_i[MSB]) && (f_o[MSB] != a_i[MSB])))
         else $error("R9: add overflow mismatch");
      // R6: subtract carry means no borrow
      assert_sub_carry_R6: assert (op_i != OP_SUB || carry_o == (a_i >= b_i))
         else $error("R6: subtract carry mismatch");
      // R7: increment carries only from all ones, leaving zero
      assert_inc_carry_R7: assert (op_i != OP_INC || carry_o == (f_o == '0))
         else $error("R7: increment carry mismatch");
      // R8: decrement carry is clear only for a zero operand
      assert_dec_carry_R8: assert (op_i != OP_DEC || carry_o == (a_i != '0))
         else $error("R8: decrement carry mismatch");
   end
endmodule

bind op8_alu op8_alu_checker #(.WIDTH(WIDTH)) u_checker (
   .a_i     (a_i),
   .b_i     (b_i),
   .op_i    (op_i),
   .f_o     (f_o),
   .carry_o (carry_o),
   .ovf_o   (ovf_o)
);

// File: tb/op8_alu_tb.sv
module op8_alu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 4;
   localparam int SPAN = 1 << W;
   localparam int MASK = SPAN - 1;
   localparam int HALF = SPAN / 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a;
   logic [W-1:0] b;
   logic [2:0]   op;
   logic [W-1:0] f;
   logic         c;
   logic         v;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   op8_alu #(.WIDTH(W)) u_dut (
      .a_i(a), .b_i(b), .op_i(op), .f_o(f), .carry_o(c), .ovf_o(v)
   );

   function automatic int sgn(input int x);
      return (x >= HALF) ? x - SPAN : x;
   endfunction

   function automatic string tag_of(input int code);
      case (code)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic expect_of(input int code, input int x, input int y,
                            output int ef, output int ec, output int ev);
      int raw;
      int sres;
      ec = 0; ev = 0; raw = 0; sres = 0;
      case (code)
         0: ef = x & y;
         1: ef = x | y;
         2: ef = (~x) & MASK;
         3: ef = x ^ y;
         4: begin raw = x + y;            sres = sgn(x) + sgn(y); end
         5: begin raw = x + (MASK - y) + 1; sres = sgn(x) - sgn(y); end
         6: begin raw = x + 1;            sres = sgn(x) + 1;      end
         default: begin raw = x + MASK;   sres = sgn(x) - 1;      end
      endcase
      if (code >= 4) begin
         ef = raw & MASK;
         ec = (raw >> W) & 1;
         ev = (sres > HALF - 1 || sres < -HALF) ? 1 : 0;
      end
   endtask

   // compares current outputs with the model; inputs must already be settled
   task automatic compare(input int code, input int x, input int y, input string why);
      int ef, ec, ev;
      string t;
      expect_of(code, x, y, ef, ec, ev);
      t = tag_of(code);
      if (code >= 4 && int'(v) != ev) t = "R9";
      if (code < 4 && (c || v)) t = "R10";
      checks++;
      if (int'(f) != ef || int'(c) != ec || int'(v) != ev) begin
         errors++;
         $display("FAIL %s %s op=%0d a=%0d b=%0d actual f=%0d c=%0d v=%0d expected f=%0d c=%0d v=%0d",
                  t, why, code, x, y, f, c, v, ef, ec, ev);
      end
   endtask

   task automatic apply(input int code, input int x, input int y, input string why);
      @(posedge clk);
      #1;
      op = code[2:0]; a = x[W-1:0]; b = y[W-1:0];
      @(negedge clk);
      compare(code, x, y, why);
   endtask

   task automatic sweep(input int code, input string why);
      for (int x = 0; x < SPAN; x++)
         for (int y = 0; y < SPAN; y++)
            apply(code, x, y, why);
   endtask

   task automatic t_idle_zero();
      apply(0, 0, 0, "zero inputs R1");
   endtask

   task automatic t_logic();
      sweep(0, "AND R1");
      sweep(1, "OR R2");
      sweep(2, "NOT R3");
      sweep(3, "XOR R4");
   endtask

   task automatic t_not_ignores_b();
      apply(2, 5, 0, "NOT b=0 R3");
      apply(2, 5, MASK, "NOT b=all ones R3");
   endtask

   task automatic t_add();
      sweep(4, "ADD R5");
      apply(4, 7, 7, "0111+0111 wrap R9");
      apply(4, 9, 9, "1001+1001 wrap R9");
      apply(4, MASK, 1, "carry out R5");
   endtask

   task automatic t_sub();
      sweep(5, "SUB R6");
      apply(5, 3, 3, "equal operands R6");
      apply(5, HALF, 1, "min minus one R9");
   endtask

   task automatic t_inc_dec();
      sweep(6, "INC R7");
      sweep(7, "DEC R8");
      apply(6, MASK, 0, "inc all ones R7");
      apply(6, HALF - 1, MASK, "inc max positive R9");
      apply(7, 0, 5, "dec zero R8");
      apply(7, HALF, 0, "dec min negative R9");
   endtask

   task automatic t_flags_quiet();
      apply(3, MASK, MASK, "xor full R10");
      apply(1, HALF, HALF, "or signs R10");
   endtask

   // R11: change inputs between edges and observe without any clock edge
   task automatic t_comb();
      @(posedge clk);
      #1; op = 3'b100; a = 4'd2; b = 4'd3;
      #1; compare(4, 2, 3, "mid-cycle R11");
      a = 4'd6;
      #1; compare(4, 6, 3, "mid-cycle R11");
      op = 3'b011;
      #1; compare(3, 6, 3, "mid-cycle R11");
   endtask

   initial begin
      a = '0; b = '0; op = '0;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_idle_zero();
      t_logic();
      t_not_ignores_b();
      t_add();
      t_sub();
      t_inc_dec();
      t_flags_quiet();
      t_comb();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule